// File: doc/BRIEF.md
# Serial Control Register Port

This block is a serial slave that lets an external controller write and read a small bank of control registers. The controller asserts chip select (active low) and toggles the serial clock. The first eight bits of each transfer form an instruction that gives the direction and the register address. The data bits for the addressed register follow. Each register has its own byte length, so the number of data bits depends on the address. The register values are driven out on parallel ports for the surrounding logic.

All serial inputs pass through synchronizers and are sampled in the system clock domain. The serial clock must therefore be slow compared with `clk`. Two bits of the control register reconfigure the port itself. One bit selects bit order: most significant bit first, or least significant bit first across the whole instruction and data word. The other bit selects the pin arrangement. In two-wire mode, read data returns on the shared data line. In three-wire mode, the shared line is input only and read data leaves on a separate output. A new setting takes effect only once chip select has been released.

The shared data line is split into an input, an output and an output enable. The pad-level tri-state buffer sits outside the block.

Top module: `serial_reg_port`

## Requirements
- R1: Instruction byte: bit 7 set means read and clear means write. Bits 5:0 are the register address. Bit 6 has no effect.
- R2: Address 0 is the 1-byte control register (bit 0 = LSB-first order, bit 1 = three-wire mode). Address 1 is the 4-byte sweep step. Address 2 is the 2-byte ramp rate. Address 3 is the 4-byte tuning word. Any other address takes 1 data byte, reads as zero, and discards writes.
- R3: A write updates its register only after the final data bit of that register has been sampled. A transfer that releases chip select earlier leaves every register unchanged.
- R4: With the order bit clear (the reset value), the instruction and the full multi-byte data word are shifted most significant bit first. With the order bit set, the least significant bit of each comes first.
- R5: Input bits are taken on serial clock rising edges. Read data bit k is driven after the falling edge that follows rising edge 8+k (counting from 1), so the controller can sample it on the next rising edge.
- R6: In two-wire mode (mode bit clear, the reset value), read data appears on `sdio_out` with `sdio_oe` high, and `sdo_oe` stays low.
- R7: In three-wire mode, `sdio_oe` never rises, and read data appears on `sdo_out` with `sdo_oe` high.
- R8: The active order and pin mode change only while chip select is released. A control-register write applies from the next transfer.
- R9: Releasing chip select turns off both output enables and clears the bit and byte counters, so the next transfer starts with a fresh instruction.
- R10: Serial clocks that arrive after the last data bit of a transfer cause no further writes and leave both outputs disabled.
- R11: After reset, all registers read zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Shared data line, input side |
| sdio_out | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line output enable |
| sdo_out | output | 1 | Dedicated read data output |
| sdo_oe | output | 1 | Dedicated read data output enable |
| ctrl_word | output | 8 | Control register |
| sweep_step | output | 32 | Sweep step register |
| ramp_rate | output | 16 | Ramp rate register |
| tune_word | output | 32 | Tuning word register |

## Verification
The bench sweeps all four combinations of order and pin mode. For each combination it writes and reads back every sized register with arithmetic patterns, so a design that reversed bits only within each byte, or that drove the wrong pin, returns garbled data or shows a wrong enable. Truncated transfers check that no register is partly committed. Over-clocked transfers check that an extra byte does not overwrite a register and that the read driver is released. Instructions with bit 6 set and unmapped addresses check that the decoder ignores the spare bit and that the byte count matches the register length. A design that switched mode on the control write itself would corrupt the rest of that transfer and break the readbacks that follow.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int ADDR_W    = 6;
    localparam int INSTR_W   = 8;
    localparam int CTRL_W    = 8;
    localparam int WORD_W    = 32;
    localparam int RAMP_W    = 16;
    localparam int IDX_W     = $clog2(WORD_W);
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int BYTES_W   = 3;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 6'd0;
    localparam logic [ADDR_W-1:0] ADDR_SWEEP = 6'd1;
    localparam logic [ADDR_W-1:0] ADDR_RAMP  = 6'd2;
    localparam logic [ADDR_W-1:0] ADDR_TUNE  = 6'd3;

    localparam int CTRL_LSB_BIT = 0;
    localparam int CTRL_3W_BIT  = 1;
    localparam int INSTR_RD_BIT = 7;

    typedef enum logic [1:0] {
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } frame_state_e;

    typedef struct packed {
        logic lsb_first;
        logic three_wire;
    } port_cfg_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    function automatic logic [BYTES_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_SWEEP: return 3'd4;
            ADDR_RAMP:  return 3'd2;
            ADDR_TUNE:  return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] reg_bits(input logic [ADDR_W-1:0] a);
        return CNT_W'({reg_bytes(a), 3'b000});
    endfunction

    function automatic logic [IDX_W-1:0] bit_pos(input logic lsb,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input logic [CNT_W-1:0] nbits);
        logic [CNT_W-1:0] msb_pos;
        msb_pos = nbits - cnt - CNT_W'(1);
        return lsb ? cnt[IDX_W-1:0] : msb_pos[IDX_W-1:0];
    endfunction

    function automatic instr_t decode_instr(input logic [INSTR_W-1:0] b);
        instr_t r;
        r.rd   = b[INSTR_RD_BIT];
        r.addr = b[ADDR_W-1:0];
        return r;
    endfunction

    function automatic port_cfg_t cfg_from_ctrl(input logic [CTRL_W-1:0] c);
        port_cfg_t r;
        r.lsb_first  = c[CTRL_LSB_BIT];
        r.three_wire = c[CTRL_3W_BIT];
        return r;
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= RST_VAL;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/srp_reg_bank.sv
module srp_reg_bank
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] sweep_q,
    output logic [RAMP_W-1:0] ramp_q,
    output logic [WORD_W-1:0] tune_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sweep_q <= '0;
            ramp_q  <= '0;
            tune_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:  ctrl_q  <= wr_word[CTRL_W-1:0];
                ADDR_SWEEP: sweep_q <= wr_word;
                ADDR_RAMP:  ramp_q  <= wr_word[RAMP_W-1:0];
                ADDR_TUNE:  tune_q  <= wr_word;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL:  rd_word = WORD_W'(ctrl_q);
            ADDR_SWEEP: rd_word = sweep_q;
            ADDR_RAMP:  rd_word = WORD_W'(ramp_q);
            ADDR_TUNE:  rd_word = tune_q;
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/srp_frame.sv
module srp_frame
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  port_cfg_t         cfg_next,
    output logic [ADDR_W-1:0] lkp_addr,
    input  logic [WORD_W-1:0] lkp_word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_word,
    output port_cfg_t         cfg_act,
    output logic              out_bit,
    output logic              out_en
);

    frame_state_e      st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nbits_q;
    logic [WORD_W-1:0] word_q;
    instr_t            instr_q;

    logic [CNT_W-1:0]  cur_nbits;
    logic [IDX_W-1:0]  pos;
    logic [WORD_W-1:0] word_nx;
    logic              last_bit;
    instr_t            instr_nx;

    always_comb begin
        cur_nbits = (st_q == ST_INSTR) ? CNT_W'(INSTR_W) : nbits_q;
        pos       = bit_pos(cfg_act.lsb_first, cnt_q, cur_nbits);
        word_nx   = word_q;
        word_nx[pos] = din;
        last_bit  = (cnt_q == cur_nbits - CNT_W'(1));
        instr_nx  = decode_instr(word_nx[INSTR_W-1:0]);
    end

    assign lkp_addr = instr_nx.addr;
    assign wr_en    = cs_active && sclk_rise && (st_q == ST_WDATA) && last_bit;
    assign wr_addr  = instr_q.addr;
    assign wr_word  = word_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_INSTR;
            cnt_q   <= '0;
            nbits_q <= '0;
            word_q  <= '0;
            instr_q <= '0;
            cfg_act <= '0;
            out_bit <= 1'b0;
            out_en  <= 1'b0;
        end else if (!cs_active) begin
            st_q    <= ST_INSTR;
            cnt_q   <= '0;
            word_q  <= '0;
            out_bit <= 1'b0;
            out_en  <= 1'b0;
            cfg_act <= cfg_next;
        end else begin
            case (st_q)
                ST_INSTR: begin
                    if (sclk_rise) begin
                        if (last_bit) begin
                            cnt_q   <= '0;
                            instr_q <= instr_nx;
                            nbits_q <= reg_bits(instr_nx.addr);
                            word_q  <= instr_nx.rd ? lkp_word : '0;
                            st_q    <= instr_nx.rd ? ST_RDATA : ST_WDATA;
                        end else begin
                            cnt_q  <= cnt_q + CNT_W'(1);
                            word_q <= word_nx;
                        end
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        word_q <= word_nx;
                        cnt_q  <= cnt_q + CNT_W'(1);
                        if (last_bit) st_q <= ST_DONE;
                    end
                end
                ST_RDATA: begin
                    if (sclk_fall) begin
                        if (cnt_q == nbits_q) begin
                            out_en  <= 1'b0;
                            out_bit <= 1'b0;
                            st_q    <= ST_DONE;
                        end else begin
                            out_bit <= word_q[pos];
                            out_en  <= 1'b1;
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    out_en  <= 1'b0;
                    out_bit <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] sweep_step,
    output logic [RAMP_W-1:0] ramp_rate,
    output logic [WORD_W-1:0] tune_word
);

    localparam int SIG_W = 3;

    logic [SIG_W-1:0]  pins_s;
    logic              sclk_d;
    logic              cs_active;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              act_lsb;
    logic              act_tw;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_word;
    logic [ADDR_W-1:0] lkp_addr;
    logic [WORD_W-1:0] lkp_word;
    logic              out_bit;
    logic              out_en;
    port_cfg_t         cfg_act;

    srp_sync #(
        .WIDTH  (SIG_W),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({cs_n, sclk, sdio_in}),
        .q  (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= pins_s[1];
    end

    assign cs_active = ~pins_s[2];
    assign sclk_rise = pins_s[1] & ~sclk_d;
    assign sclk_fall = ~pins_s[1] & sclk_d;

    srp_reg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_word(wr_word),
        .rd_addr(lkp_addr),
        .rd_word(lkp_word),
        .ctrl_q (ctrl_word),
        .sweep_q(sweep_step),
        .ramp_q (ramp_rate),
        .tune_q (tune_word)
    );

    srp_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_active(cs_active),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .din      (pins_s[0]),
        .cfg_next (cfg_from_ctrl(ctrl_word)),
        .lkp_addr (lkp_addr),
        .lkp_word (lkp_word),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (wr_word),
        .cfg_act  (cfg_act),
        .out_bit  (out_bit),
        .out_en   (out_en)
    );

    assign act_lsb  = cfg_act.lsb_first;
    assign act_tw   = cfg_act.three_wire;
    assign sdio_oe  = out_en & ~act_tw;
    assign sdo_oe   = out_en & act_tw;
    assign sdio_out = out_bit & sdio_oe;
    assign sdo_out  = out_bit & sdo_oe;

endmodule

// File: rtl/srp_checker.sv
module srp_checker (
    input logic clk,
    input logic rst,
    input logic cs_active,
    input logic act_lsb,
    input logic act_tw,
    input logic sdio_oe,
    input logic sdo_oe,
    input logic wr_en
);

    // R6
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    // R7
    three_wire_sdio_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        act_tw |-> !sdio_oe);

    // R6
    two_wire_sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !act_tw |-> !sdo_oe);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_active && $past(cs_active)) |-> ($stable(act_lsb) && $stable(act_tw)));

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> (!sdio_oe && !sdo_oe));

    // R3
    write_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> cs_active);

endmodule

bind serial_reg_port srp_checker u_srp_checker (
    .clk      (clk),
    .rst      (rst),
    .cs_active(cs_active),
    .act_lsb  (act_lsb),
    .act_tw   (act_tw),
    .sdio_oe  (sdio_oe),
    .sdo_oe   (sdo_oe),
    .wr_en    (wr_en)
);

// File: tb/serial_reg_port_bench.sv
module serial_reg_port_bench;

    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [7:0]  ctrl_word;
    logic [31:0] sweep_step, tune_word;
    logic [15:0] ramp_rate;

    int checks = 0;
    int fails  = 0;

    logic        cur_lsb = 1'b0;
    logic        cur_tw  = 1'b0;
    logic [7:0]  exp_ctrl = '0;
    logic [31:0] exp_sweep = '0, exp_tune = '0;
    logic [15:0] exp_ramp = '0;

    always #4 clk = ~clk;

    serial_reg_port u_serial_reg_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .ctrl_word(ctrl_word), .sweep_step(sweep_step), .ramp_rate(ramp_rate),
        .tune_word(tune_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int nbytes_of(input logic [5:0] a);
        case (a)
            6'd1, 6'd3: return 4;
            6'd2:       return 2;
            default:    return 1;
        endcase
    endfunction

    task automatic xfer(input logic [7:0] instr, input int nbytes, input logic [31:0] wdata,
                        input int nsent, output logic [31:0] rdata, output int oe_bad);
        logic rd;
        int   nd;
        rd = instr[7];
        nd = nbytes * 8;
        rdata = '0;
        oe_bad = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nsent; i++) begin
            logic b;
            int   j;
            j = i - 8;
            if (i < 8)       b = instr[cur_lsb ? i : 7 - i];
            else if (j < nd) b = wdata[cur_lsb ? j : nd - 1 - j];
            else             b = 1'b1;
            sdio_in = (rd && i >= 8) ? 1'b0 : b;
            repeat (HP) @(negedge clk);
            if (rd && i >= 8) begin
                if (j < nd) begin
                    rdata[cur_lsb ? j : nd - 1 - j] = cur_tw ? sdo_out : sdio_out;
                    if ((cur_tw ? sdo_oe : sdio_oe) !== 1'b1) oe_bad++;
                    if ((cur_tw ? sdio_oe : sdo_oe) !== 1'b0) oe_bad++;
                end else if (sdio_oe || sdo_oe) begin
                    oe_bad++;
                end
            end
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        sdio_in = 1'b0;
        repeat (2 * HP) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        int bad;
        int nb;
        nb = nbytes_of(a);
        xfer({2'b00, a}, nb, d, 8 + nb * 8, dummy, bad);
        case (a)
            6'd0: begin exp_ctrl = d[7:0]; cur_lsb = d[0]; cur_tw = d[1]; end
            6'd1: exp_sweep = d;
            6'd2: exp_ramp = d[15:0];
            6'd3: exp_tune = d;
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d, output int bad);
        int nb;
        nb = nbytes_of(a);
        xfer({2'b10, a}, nb, '0, 8 + nb * 8, d, bad);
    endtask

    function automatic logic [31:0] exp_of(input logic [5:0] a);
        case (a)
            6'd0: return {24'h0, exp_ctrl};
            6'd1: return exp_sweep;
            6'd2: return {16'h0, exp_ramp};
            6'd3: return exp_tune;
            default: return '0;
        endcase
    endfunction

    task automatic chk_ports(input string req);
        chk(ctrl_word == exp_ctrl, req, "ctrl_word", {24'h0, ctrl_word}, {24'h0, exp_ctrl});
        chk(sweep_step == exp_sweep, req, "sweep_step", sweep_step, exp_sweep);
        chk(ramp_rate == exp_ramp, req, "ramp_rate", {16'h0, ramp_rate}, {16'h0, exp_ramp});
        chk(tune_word == exp_tune, req, "tune_word", tune_word, exp_tune);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired before the sequence finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        int bad;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk_ports("R11");
        chk(!sdio_oe && !sdo_oe, "R11", "oe after reset", {30'h0, sdio_oe, sdo_oe}, 0);

        // R4 R2 MSB-first write and readback, R5 R6 two-wire read
        wr(6'd1, 32'hA1B2C3D4);
        chk_ports("R4");
        rd_reg(6'd1, r, bad);
        chk(r == 32'hA1B2C3D4, "R5", "sweep read msb", r, 32'hA1B2C3D4);
        chk(bad == 0, "R6", "two-wire enables", bad, 0);

        wr(6'd2, 32'h0000BEEF);
        wr(6'd3, 32'h0F1E2D3C);
        chk_ports("R2");
        rd_reg(6'd2, r, bad);
        chk(r == 32'h0000BEEF, "R2", "ramp read", r, 32'h0000BEEF);

        // R2 unmapped address
        wr(6'h2A, 32'h000000FF);
        chk_ports("R2");
        rd_reg(6'h2A, r, bad);
        chk(r == 32'h0, "R2", "unmapped read", r, 0);

        // R1 bit 6 ignored
        xfer(8'hC1, 4, '0, 40, r, bad);
        chk(r == exp_sweep, "R1", "read with bit6", r, exp_sweep);
        xfer(8'h42, 2, 32'h00001234, 24, r, bad);
        exp_ramp = 16'h1234;
        chk_ports("R1");

        // R3 truncated write
        xfer(8'h01, 4, 32'h55AA55AA, 24, r, bad);
        chk_ports("R3");
        // R9 next transfer starts fresh
        wr(6'd1, 32'h55AA55AA);
        chk_ports("R9");

        // R9 truncated read releases the line
        xfer(8'h83, 4, '0, 13, r, bad);
        chk(!sdio_oe && !sdo_oe, "R9", "oe after cut read", {30'h0, sdio_oe, sdo_oe}, 0);

        // R10 extra clocks
        xfer(8'h02, 2, 32'h00007777, 33, r, bad);
        exp_ramp = 16'h7777;
        chk_ports("R10");
        xfer(8'h82, 2, '0, 33, r, bad);
        chk(r == 32'h00007777, "R10", "read with extra clocks", r, 32'h7777);
        chk(bad == 0, "R10", "outputs released after data", bad, 0);

        // R8 R4 switch to LSB-first, effective from next transfer
        wr(6'd0, 32'h00000001);
        chk_ports("R8");
        wr(6'd1, 32'h12345678);
        chk_ports("R4");
        rd_reg(6'd1, r, bad);
        chk(r == 32'h12345678, "R4", "lsb-first read", r, 32'h12345678);

        // R7 three-wire
        wr(6'd0, 32'h00000003);
        rd_reg(6'd3, r, bad);
        chk(r == exp_tune, "R7", "three-wire read", r, exp_tune);
        chk(bad == 0, "R7", "three-wire enables", bad, 0);

        // sweep over all order / pin-mode combinations
        for (int m = 0; m < 4; m++) begin
            wr(6'd0, 32'(m));
            for (int a = 1; a < 4; a++) begin
                logic [31:0] pat;
                int nb;
                nb = nbytes_of(6'(a));
                pat = 32'h9E3779B9 * 32'(m * 4 + a + 1);
                if (nb == 2) pat = pat & 32'h0000FFFF;
                wr(6'(a), pat);
                chk(exp_of(6'(a)) == pat, "R4", "shadow", exp_of(6'(a)), pat);
                chk_ports("R4");
                rd_reg(6'(a), r, bad);
                chk(r == pat, m[1] ? "R7" : "R6", "sweep readback", r, pat);
                chk(bad == 0, m[1] ? "R7" : "R6", "sweep enables", bad, 0);
            end
            rd_reg(6'd0, r, bad);
            chk(r == 32'(m), "R8", "ctrl readback", r, 32'(m));
        end

        summary();
        $finish;
    end

endmodule